// File: doc/BRIEF.md
# Interrupt Request Combiner

This block gathers interrupt requests from six peripheral sources into a pending register and drives one interrupt line toward the processor. Each source raises its request with a one-cycle pulse. The request stays pending until that source's peripheral sends an acknowledge pulse. One source can also be cleared by a write to this block's control register.

Software controls a per-source enable mask through paired set and clear bits in a single write, so it never has to read the mask and write it back. The processor line is a registered level. It is high exactly when some source is both pending and enabled. It is recomputed on every raise, acknowledge and mask write, so enabling a source that is already pending brings the line up at once and no request is lost.

Source index order is 0..5; index 5 is the source that the control-register write can clear.

Top module: `irq_combiner`

## Requirements
- R1: After reset, `pending`, `mask` and `cpuIrq` are all zero.
- R2: A pulse on `raise[i]` sets `pending[i]` one cycle later, whatever the state of `mask[i]`. A pending bit never becomes 1 without a raise.
- R3: In every cycle after reset, `cpuIrq` equals the OR of (`pending` AND `mask`). It changes in the same cycle as the registers it depends on, one clock after the event.
- R4: A bus write to address 2 updates the mask. Data bit 2i+1 sets `mask[i]` and data bit 2i clears it. When both bits are 1, the set wins. When neither is 1, `mask[i]` keeps its value.
- R5: A mask write that enables a source that is already pending drives `cpuIrq` high on the next cycle.
- R6: An `ack[i]` pulse clears `pending[i]`. `cpuIrq` then falls only if no other enabled source is still pending.
- R7: When `raise[i]` and a clear of source i occur in the same cycle, `pending[i]` ends up 1.
- R8: Pending is read-only: a bus write to address 1 changes neither `pending` nor `mask`.
- R9: A bus write to address 0 with data bit 0 set clears `pending[5]`. With data bit 0 clear, the write has no effect.
- R10: `busRdData` is combinational on `busAddr`: `pending` zero-extended at address 1, `mask` zero-extended at address 2, and zero at every other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raise | input | 6 | Per-source request pulses |
| ack | input | 6 | Per-source acknowledge pulses from the peripherals |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | ADDR_W (3) | Register address for reads and writes |
| busWrData | input | DATA_W (32) | Write data |
| busRdData | output | DATA_W (32) | Read data for `busAddr` |
| pending | output | 6 | Pending request register |
| mask | output | 6 | Enable mask register |
| cpuIrq | output | 1 | Combined interrupt line to the processor |

## Verification
The assertions check on every cycle the invariants that do not depend on history. The line always matches the enabled pending set. Each raise shows up in the pending register, and no pending bit appears without one. Each mask write lands with set taking precedence over clear. A write to the pending address leaves the state unchanged, and the read data matches the registers.

Other behaviours depend on a sequence of steps, and only the bench scenarios can show them. These are the recovery of a request that was already pending when its mask bit is enabled, and the line staying high after one acknowledge while another enabled request remains. The same applies to a raise and a clear colliding in one cycle and to the control-register clear of source 5. These are run as directed scenarios and then under random traffic against the reference model.

// File: rtl/irq_combiner_pkg.sv
`timescale 1ns/1ps
package irq_combiner_pkg;
  localparam int SRC_COUNT   = 6;
  localparam int CLR_SRC_IDX = SRC_COUNT - 1;
  localparam int REG_CTRL    = 0;
  localparam int REG_PEND    = 1;
  localparam int REG_MASK    = 2;

  typedef logic [SRC_COUNT-1:0] srcVec_t;

  // strobes from control to datapath; set/clear already resolved
  typedef struct packed {
    srcVec_t maskSet;
    srcVec_t maskClr;
    srcVec_t clearPend;
  } strobes_t;
endpackage

// File: rtl/irq_ctrl.sv
`timescale 1ns/1ps
module irq_ctrl
  import irq_combiner_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  srcVec_t           ack,
  output strobes_t          strobes
);
  localparam int PAIR_BITS = 2 * SRC_COUNT;

  srcVec_t setBits, clrBits, ctrlClear;
  logic    wrMask, wrCtrl;
  logic    unusedHighBits;

  assign wrMask = busWrEn && (busAddr == ADDR_W'(REG_MASK));
  assign wrCtrl = busWrEn && (busAddr == ADDR_W'(REG_CTRL));
  assign unusedHighBits = ^busWrData[DATA_W-1:PAIR_BITS];

  // split the write word into per-source set/clear pairs
  for (genvar i = 0; i < SRC_COUNT; i++) begin : g_pair
    assign clrBits[i] = busWrData[2*i];
    assign setBits[i] = busWrData[2*i+1];
  end

  always_comb begin
    ctrlClear = '0;
    if (wrCtrl && busWrData[0]) ctrlClear[CLR_SRC_IDX] = 1'b1;
  end

  always_comb begin
    strobes.maskSet   = wrMask ? setBits : '0;
    strobes.maskClr   = wrMask ? (clrBits & ~setBits) : '0;  // set wins
    strobes.clearPend = ack | ctrlClear;
  end
endmodule

// File: rtl/irq_datapath.sv
`timescale 1ns/1ps
module irq_datapath
  import irq_combiner_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  srcVec_t           raise,
  input  strobes_t          strobes,
  input  logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busRdData,
  output srcVec_t           pending,
  output srcVec_t           mask,
  output logic              cpuIrq
);
  srcVec_t pendNext, maskNext;

  // raise beats a same-cycle clear
  assign pendNext = raise | (pending & ~strobes.clearPend);
  assign maskNext = (mask & ~strobes.maskClr) | strobes.maskSet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
      mask    <= '0;
      cpuIrq  <= 1'b0;
    end else begin
      pending <= pendNext;
      mask    <= maskNext;
      cpuIrq  <= |(pendNext & maskNext);
    end
  end

  always_comb begin
    busRdData = '0;
    if (busAddr == ADDR_W'(REG_PEND))      busRdData[SRC_COUNT-1:0] = pending;
    else if (busAddr == ADDR_W'(REG_MASK)) busRdData[SRC_COUNT-1:0] = mask;
  end
endmodule

// File: rtl/irq_combiner.sv
`timescale 1ns/1ps
module irq_combiner
  import irq_combiner_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        raise,
  input  logic [5:0]        ack,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic [5:0]        pending,
  output logic [5:0]        mask,
  output logic              cpuIrq
);
  strobes_t strobes;

  irq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .ack(ack), .strobes(strobes)
  );

  irq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .raise(raise), .strobes(strobes),
    .busAddr(busAddr), .busRdData(busRdData),
    .pending(pending), .mask(mask), .cpuIrq(cpuIrq)
  );
endmodule

// File: rtl/irq_combiner_checker.sv
`timescale 1ns/1ps
module irq_combiner_checker #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [5:0]        raise,
  input logic [5:0]        ack,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic [5:0]        pending,
  input logic [5:0]        mask,
  input logic              cpuIrq
);
  logic [5:0] wSet, wClr;
  logic       maskWrite, pendWrite;

  always_comb begin
    for (int i = 0; i < 6; i++) begin
      wClr[i] = busWrData[2*i];
      wSet[i] = busWrData[2*i+1];
    end
  end
  assign maskWrite = busWrEn && (busAddr == ADDR_W'(2));
  assign pendWrite = busWrEn && (busAddr == ADDR_W'(1));

  AST_LINE_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    cpuIrq == |(pending & mask)); // R3

  AST_RAISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (raise != 6'b0) |=> ((pending & $past(raise)) == $past(raise))); // R2

  AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
    ((pending & ~$past(pending) & ~$past(raise)) == 6'b0)); // R2

  AST_MASK_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    maskWrite |=> (((mask & $past(wSet)) == $past(wSet)) &&
                   ((mask & $past(wClr & ~wSet)) == 6'b0))); // R4

  AST_PEND_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (pendWrite && raise == 6'b0 && ack == 6'b0) |=> ($stable(pending) && $stable(mask))); // R8

  AST_READ_MUX: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr == ADDR_W'(1)) |-> (busRdData == DATA_W'(pending))); // R10
endmodule

bind irq_combiner irq_combiner_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .raise(raise), .ack(ack), .busWrEn(busWrEn),
  .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
  .pending(pending), .mask(mask), .cpuIrq(cpuIrq)
);

// File: tb/irq_combiner_bench.sv
`timescale 1ns/1ps
module irq_combiner_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  raise = '0, ack = '0;
  logic        busWrEn = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [5:0]  pending, mask;
  logic        cpuIrq;

  int compared = 0, mismatched = 0;
  bit done = 0;

  // reference state
  logic [5:0] mPend = '0, mMask = '0;
  logic       mIrq = 1'b0;

  always #2 clk = ~clk;

  irq_combiner u_irq_combiner (
    .clk(clk), .rst_n(rst_n), .raise(raise), .ack(ack), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .pending(pending), .mask(mask), .cpuIrq(cpuIrq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic [5:0] clr, np, nm;
    if (!rst_n) begin
      mPend <= '0; mMask <= '0; mIrq <= 1'b0;
    end else begin
      clr = ack;
      if (busWrEn && busAddr == 3'd0 && busWrData[0]) clr[5] = 1'b1;
      np = mPend; nm = mMask;
      for (int i = 0; i < 6; i++) begin
        if (raise[i]) np[i] = 1'b1;
        else if (clr[i]) np[i] = 1'b0;
        if (busWrEn && busAddr == 3'd2) begin
          if (busWrData[2*i+1]) nm[i] = 1'b1;
          else if (busWrData[2*i]) nm[i] = 1'b0;
        end
      end
      mPend <= np; mMask <= nm; mIrq <= |(np & nm);
    end
  end

  always @(negedge clk) begin
    logic [31:0] rd;
    rd = 0;
    if (busAddr == 3'd1) rd = {26'b0, mPend};
    else if (busAddr == 3'd2) rd = {26'b0, mMask};
    chk("R2 pending model", {26'b0, pending}, {26'b0, mPend});
    chk("R4 mask model", {26'b0, mask}, {26'b0, mMask});
    chk("R3 cpuIrq model", {31'b0, cpuIrq}, {31'b0, mIrq});
    chk("R10 rdData model", busRdData, rd);
  end

  // drive one cycle of stimulus, then return to idle just after the next negedge
  task automatic doCycle(input logic [5:0] r, input logic [5:0] a, input logic we,
                         input logic [2:0] ad, input logic [31:0] wd);
    raise = r; ack = a; busWrEn = we; busAddr = ad; busWrData = wd;
    @(negedge clk); #1;
    raise = '0; ack = '0; busWrEn = 1'b0; busAddr = '0; busWrData = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 pending reset", {26'b0, pending}, 0);
    chk("R1 mask reset", {26'b0, mask}, 0);
    chk("R1 cpuIrq reset", {31'b0, cpuIrq}, 0);

    doCycle(6'h08, 0, 0, 0, 0);
    chk("R2 raise masked sets pending", {26'b0, pending}, 32'h08);
    chk("R2 masked raise keeps line low", {31'b0, cpuIrq}, 0);

    doCycle(0, 0, 1, 3'd2, 32'h80);          // set bit for source 3
    chk("R5 enable pending source", {31'b0, cpuIrq}, 1);
    chk("R4 set bit", {26'b0, mask}, 32'h08);

    doCycle(0, 0, 1, 3'd2, 32'h03);          // set and clear for source 0
    chk("R4 set wins over clear", {26'b0, mask}, 32'h09);

    doCycle(0, 0, 1, 3'd2, 32'h40);          // clear source 3
    chk("R4 clear bit", {26'b0, mask}, 32'h01);
    chk("R3 line drops when disabled", {31'b0, cpuIrq}, 0);

    doCycle(6'h01, 0, 0, 0, 0);
    chk("R3 enabled raise lifts line", {31'b0, cpuIrq}, 1);

    doCycle(0, 0, 1, 3'd2, 32'h80);
    doCycle(0, 6'h01, 0, 0, 0);
    chk("R6 ack clears bit", {26'b0, pending}, 32'h08);
    chk("R6 line held by other source", {31'b0, cpuIrq}, 1);

    doCycle(0, 6'h08, 0, 0, 0);
    chk("R6 last ack drops line", {31'b0, cpuIrq}, 0);

    doCycle(6'h04, 6'h04, 0, 0, 0);
    chk("R7 raise beats ack", {26'b0, pending}, 32'h04);

    doCycle(0, 0, 1, 3'd1, 32'h3F);
    chk("R8 pending write ignored", {26'b0, pending}, 32'h04);
    chk("R8 mask untouched", {26'b0, mask}, 32'h09);

    doCycle(6'h20, 0, 0, 0, 0);
    doCycle(0, 0, 1, 3'd0, 32'h02);
    chk("R9 ctrl write without bit0", {26'b0, pending}, 32'h24);
    doCycle(0, 0, 1, 3'd0, 32'h01);
    chk("R9 ctrl clear of source 5", {26'b0, pending}, 32'h04);

    busAddr = 3'd1; #1;
    chk("R10 read pending", busRdData, 32'h04);
    busAddr = 3'd2; #1;
    chk("R10 read mask", busRdData, 32'h09);
    busAddr = 3'd5; #1;
    chk("R10 unmapped read", busRdData, 0);
    busAddr = 3'd0;

    for (int n = 0; n < 600; n++) begin
      logic [31:0] wd;
      wd = $urandom;
      doCycle(6'($urandom & $urandom), 6'($urandom & $urandom),
              1'($urandom), 3'($urandom & 3), wd);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule